// File: doc/BRIEF.md
# Interleaved Memory Decoder Target Lookup

This block resolves which downstream port serves a host physical address. It walks a bank of address decoders, each described by a base, a size, a control word, a commit flag and a list of eight port numbers. It finds the first decoder whose range holds the address. Within that decoder it uses the interleave granularity and the number of ways to pick one entry of the port list. The result is a found flag, an 8-bit port number and a one-cycle done pulse.

The surrounding logic owns the decoder registers and presents them as flat word vectors. It also supplies how many decoders are implemented. A lookup starts with a strobe that carries the address. The search examines one decoder per clock and stops at the first range hit.

Top module: `hdm_target_lookup`

## Requirements
- R1: After synchronous reset, done, found and port are all 0.
- R2: A decoder's 64-bit base is formed from its high word (bits 63:32) and bits 31:28 of its low word, with bits 27:0 forced to 0. The size is built the same way from its own pair of words. Bits 27:0 of both low words have no effect on the result.
- R3: A decoder's range holds the address when base <= address < base + size. The sum is taken with 65 bits, so a range that reaches past 2^64 does not wrap to cover low addresses.
- R4: Decoders are examined from index 0 upward, and the lowest-indexed range hit determines the result even if later decoders also hold the address.
- R5: If the lowest-indexed range hit belongs to a decoder whose committed input is 0, the result is found=0 and port=0, whatever later decoders hold.
- R6: The control word gives the granularity code in bits 3:0 and the ways code in bits 5:4. Its other bits are ignored. The target index is (address / (256 << granularity code)) mod 2^(ways code).
- R7: Target indices 0..3 select bytes 0..3 (byte 0 = bits 7:0) of the decoder's low target word. Indices 4..7 select bytes 0..3 of its high target word.
- R8: When no examined decoder holds the address, found=0 and port=0.
- R9: Only decoders with index below the count input are examined. A count above the number of decoders is treated as the full number.
- R10: done is high for exactly one cycle per lookup. Counting the clock edge that samples start as edge 0, done goes high after edge m+1 for a first hit at index m. For a miss it goes high after edge max(n,1), where n is the effective count.
- R11: A start strobe during a lookup is ignored. found and port change only in the cycle in which done is high, and they hold their values between lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a lookup when idle |
| addr | input | 64 | Host physical address, sampled with start |
| dec_count | input | CNT_W | Number of decoders to examine, sampled with start |
| dec_base_lo | input | NUM_DEC*32 | Base low words, decoder i at bits [32i+31:32i] |
| dec_base_hi | input | NUM_DEC*32 | Base high words |
| dec_size_lo | input | NUM_DEC*32 | Size low words |
| dec_size_hi | input | NUM_DEC*32 | Size high words |
| dec_ctrl | input | NUM_DEC*32 | Control words (granularity, ways) |
| dec_tgt_lo | input | NUM_DEC*32 | Target list entries 0..3 |
| dec_tgt_hi | input | NUM_DEC*32 | Target list entries 4..7 |
| dec_committed | input | NUM_DEC | Committed flag per decoder |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Lookup result valid and committed |
| port | output | 8 | Selected downstream port number |

## Verification
The done pulse is due after a number of edges that depends on where the first range hit lies. It comes after edge m+1 for a hit at index m and after edge max(n,1) for a miss. The bench derives this count from its own model and compares it with the measured count. It samples on the falling edge after each rising edge following the start edge, and it also confirms that done is low again one cycle later. found and port are compared in the same sampling slot where done is first seen high. During an injected start strobe mid-search, the bench checks that the result and timing still belong to the first address.

// File: rtl/hdm_lookup_pkg.sv
package hdm_lookup_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HPA_W   = 64;
  localparam int unsigned ALIGN_W = 28;
  localparam int unsigned PORT_W  = 8;

  typedef struct packed {
    logic [HPA_W-1:0] base;
    logic [HPA_W-1:0] size;
    logic [3:0]       gran_code;
    logic [1:0]       ways_code;
    logic [HPA_W-1:0] tgt_list;
    logic             committed;
  } dec_view_t;

  function automatic logic [HPA_W-1:0] join_aligned(input logic [WORD_W-1:0] lo,
                                                    input logic [WORD_W-1:0] hi);
    return {hi, lo[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  endfunction

endpackage

// File: rtl/hdm_dec_mux.sv
module hdm_dec_mux
  import hdm_lookup_pkg::*;
#(
  parameter int unsigned NUM_DEC = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [IDX_W-1:0]          sel,
  input  logic [NUM_DEC*WORD_W-1:0] base_lo,
  input  logic [NUM_DEC*WORD_W-1:0] base_hi,
  input  logic [NUM_DEC*WORD_W-1:0] size_lo,
  input  logic [NUM_DEC*WORD_W-1:0] size_hi,
  input  logic [NUM_DEC*WORD_W-1:0] ctrl,
  input  logic [NUM_DEC*WORD_W-1:0] tgt_lo,
  input  logic [NUM_DEC*WORD_W-1:0] tgt_hi,
  input  logic [NUM_DEC-1:0]        committed,
  output dec_view_t                 view
);

  dec_view_t views [NUM_DEC];

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_view
    always_comb begin
      views[g].base      = join_aligned(base_lo[g*WORD_W +: WORD_W], base_hi[g*WORD_W +: WORD_W]);
      views[g].size      = join_aligned(size_lo[g*WORD_W +: WORD_W], size_hi[g*WORD_W +: WORD_W]);
      views[g].gran_code = ctrl[g*WORD_W +: 4];
      views[g].ways_code = ctrl[g*WORD_W + 4 +: 2];
      views[g].tgt_list  = {tgt_hi[g*WORD_W +: WORD_W], tgt_lo[g*WORD_W +: WORD_W]};
      views[g].committed = committed[g];
    end
  end

  always_comb begin
    view = '0;
    for (int i = 0; i < NUM_DEC; i++) begin
      if (sel == IDX_W'(i)) view = views[i];
    end
  end

endmodule

// File: rtl/hdm_range_cmp.sv
module hdm_range_cmp
  import hdm_lookup_pkg::*;
(
  input  logic [HPA_W-1:0] addr,
  input  logic [HPA_W-1:0] base,
  input  logic [HPA_W-1:0] size,
  output logic             hit
);

  logic [HPA_W:0] addr_x;
  logic [HPA_W:0] lo_x;
  logic [HPA_W:0] end_x;

  always_comb begin
    addr_x = {1'b0, addr};
    lo_x   = {1'b0, base};
    end_x  = {1'b0, base} + {1'b0, size};
    hit    = (addr_x >= lo_x) && (addr_x < end_x);
  end

endmodule

// File: rtl/hdm_port_pick.sv
module hdm_port_pick
  import hdm_lookup_pkg::*;
(
  input  logic [HPA_W-1:0]  addr,
  input  logic [3:0]        gran_code,
  input  logic [1:0]        ways_code,
  input  logic [HPA_W-1:0]  tgt_list,
  output logic [PORT_W-1:0] port
);

  logic [4:0]       shift;
  logic [HPA_W-1:0] chunk;
  logic [2:0]       way_mask;
  logic [2:0]       tidx;

  always_comb begin
    shift    = 5'd8 + {1'b0, gran_code};
    chunk    = addr >> shift;
    way_mask = 3'((4'd1 << ways_code) - 4'd1);
    tidx     = chunk[2:0] & way_mask;
    port     = tgt_list[{tidx, 3'b000} +: PORT_W];
  end

endmodule

// File: rtl/hdm_target_lookup.sv
module hdm_target_lookup
  import hdm_lookup_pkg::*;
#(
  parameter int unsigned NUM_DEC = 4,
  localparam int unsigned IDX_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1,
  localparam int unsigned CNT_W  = $clog2(NUM_DEC + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [HPA_W-1:0]          addr,
  input  logic [CNT_W-1:0]          dec_count,
  input  logic [NUM_DEC*WORD_W-1:0] dec_base_lo,
  input  logic [NUM_DEC*WORD_W-1:0] dec_base_hi,
  input  logic [NUM_DEC*WORD_W-1:0] dec_size_lo,
  input  logic [NUM_DEC*WORD_W-1:0] dec_size_hi,
  input  logic [NUM_DEC*WORD_W-1:0] dec_ctrl,
  input  logic [NUM_DEC*WORD_W-1:0] dec_tgt_lo,
  input  logic [NUM_DEC*WORD_W-1:0] dec_tgt_hi,
  input  logic [NUM_DEC-1:0]        dec_committed,
  output logic                      done,
  output logic                      found,
  output logic [PORT_W-1:0]         port
);

  logic               busy_q;
  logic [IDX_W-1:0]   idx_q;
  logic [HPA_W-1:0]   addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_eff;
  logic               done_q;
  logic               found_q;
  logic [PORT_W-1:0]  port_q;

  dec_view_t          cur;
  logic               hit;
  logic [PORT_W-1:0]  pick;
  logic               none_left;
  logic               last_one;

  assign cnt_eff = (32'(dec_count) > NUM_DEC) ? CNT_W'(NUM_DEC) : dec_count;

  hdm_dec_mux #(.NUM_DEC(NUM_DEC), .IDX_W(IDX_W)) u_mux (
    .sel       (idx_q),
    .base_lo   (dec_base_lo),
    .base_hi   (dec_base_hi),
    .size_lo   (dec_size_lo),
    .size_hi   (dec_size_hi),
    .ctrl      (dec_ctrl),
    .tgt_lo    (dec_tgt_lo),
    .tgt_hi    (dec_tgt_hi),
    .committed (dec_committed),
    .view      (cur)
  );

  hdm_range_cmp u_cmp (
    .addr (addr_q),
    .base (cur.base),
    .size (cur.size),
    .hit  (hit)
  );

  hdm_port_pick u_pick (
    .addr      (addr_q),
    .gran_code (cur.gran_code),
    .ways_code (cur.ways_code),
    .tgt_list  (cur.tgt_list),
    .port      (pick)
  );

  assign none_left = (32'(idx_q) >= 32'(cnt_q));
  assign last_one  = ((32'(idx_q) + 32'd1) == 32'(cnt_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      port_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          addr_q <= addr;
          cnt_q  <= cnt_eff;
        end
      end else if (none_left) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        found_q <= 1'b0;
        port_q  <= '0;
      end else if (hit) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        found_q <= cur.committed;
        port_q  <= cur.committed ? pick : '0;
      end else if (last_one) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        found_q <= 1'b0;
        port_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign done  = done_q;
  assign found = found_q;
  assign port  = port_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R10

  AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_q && !found_q) |-> (port_q == '0)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(found_q) && $stable(port_q))); // R11

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> ($stable(addr_q) && $stable(cnt_q))); // R11

  AST_IDX_IN_COUNT: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((32'(idx_q) < 32'(cnt_q)) || (cnt_q == '0))); // R9

  AST_COUNT_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (32'(cnt_q) <= NUM_DEC)); // R9

endmodule

// File: tb/hdm_target_lookup_bench.sv
module hdm_target_lookup_bench;

  localparam int N  = 4;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [63:0]   addr;
  logic [CW-1:0] dec_count;
  logic [N*32-1:0] f_bl, f_bh, f_sl, f_sh, f_ct, f_tl, f_th;
  logic [N-1:0]  cm;
  logic          done, found;
  logic [7:0]    port;

  logic [31:0] bl [N];
  logic [31:0] bh [N];
  logic [31:0] sl [N];
  logic [31:0] sh [N];
  logic [31:0] ct [N];
  logic [31:0] tl [N];
  logic [31:0] th [N];

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      f_bl[i*32 +: 32] = bl[i];
      f_bh[i*32 +: 32] = bh[i];
      f_sl[i*32 +: 32] = sl[i];
      f_sh[i*32 +: 32] = sh[i];
      f_ct[i*32 +: 32] = ct[i];
      f_tl[i*32 +: 32] = tl[i];
      f_th[i*32 +: 32] = th[i];
    end
  end

  hdm_target_lookup #(.NUM_DEC(N)) u_hdm_target_lookup (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .dec_count(dec_count),
    .dec_base_lo(f_bl), .dec_base_hi(f_bh), .dec_size_lo(f_sl), .dec_size_hi(f_sh),
    .dec_ctrl(f_ct), .dec_tgt_lo(f_tl), .dec_tgt_hi(f_th), .dec_committed(cm),
    .done(done), .found(found), .port(port)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] a, input int cnt,
                       output bit ef, output logic [7:0] ep, output int el);
    int n;
    logic [64:0] b, e;
    logic [63:0] gran, tid;
    logic [63:0] lst;
    n  = (cnt > N) ? N : cnt;
    ef = 1'b0;
    ep = 8'h0;
    el = (n < 1) ? 1 : n;
    for (int i = 0; i < n; i++) begin
      b = {1'b0, bh[i], bl[i][31:28], 28'h0};
      e = b + {1'b0, sh[i], sl[i][31:28], 28'h0};
      if ({1'b0, a} >= b && {1'b0, a} < e) begin
        el = i + 1;
        if (cm[i]) begin
          ef   = 1'b1;
          gran = 64'd256 << ct[i][3:0];
          tid  = (a / gran) % (64'd1 << ct[i][5:4]);
          lst  = {th[i], tl[i]};
          ep   = lst[tid*8 +: 8];
        end
        return;
      end
    end
  endtask

  task automatic lookup(input logic [63:0] a, input int cnt, input string tag, input bit poke);
    bit ef;
    logic [7:0] ep;
    int el, lat;
    model(a, cnt, ef, ep, el);
    @(negedge clk);
    addr = a;
    dec_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      if (poke && lat == 0) begin
        start = 1'b1;
        addr  = ~a;
        dec_count = CW'(N);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R10", {tag, " done seen"}, 64'(done), 64'd1);
    chk(lat == el, "R10", {tag, " latency"}, 64'(lat), 64'(el));
    chk(found === ef, tag, "found", 64'(found), 64'(ef));
    chk(port === ep, tag, "port", 64'(port), 64'(ep));
    @(negedge clk);
    chk(done === 1'b0, "R10", {tag, " done single cycle"}, 64'(done), 64'd0);
    chk(found === ef && port === ep, "R11", {tag, " result held"}, {55'd0, found, port}, {55'd0, ef, ep});
  endtask

  task automatic set_dec(input int i, input logic [63:0] base, input logic [63:0] size,
                         input logic [31:0] ctrl, input logic [63:0] tgts, input bit c);
    bl[i] = base[31:0];  bh[i] = base[63:32];
    sl[i] = size[31:0];  sh[i] = size[63:32];
    ct[i] = ctrl;
    tl[i] = tgts[31:0];  th[i] = tgts[63:32];
    cm[i] = c;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    bit ef;
    logic [7:0] ep;
    int el;
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; addr = '0; dec_count = '0;
    for (int i = 0; i < N; i++) set_dec(i, 64'h0, 64'h0, 32'h0, 64'h0, 1'b0);
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && found === 1'b0 && port === 8'h0, "R1", "reset state",
        {55'd0, done, found, port[6:0]}, 64'd0);
    rst = 1'b0;

    // R6 R7: explicit index 5 of an 8-way, 1 KiB-granular decoder at base 0
    set_dec(0, 64'h0, 64'h1000_0000, 32'hFFFF_FFB2, 64'h1716_1514_1312_1110, 1'b1);
    set_dec(1, 64'h2_0000_0000, 64'h1000_0000, 32'h0, 64'h0, 1'b1);
    set_dec(2, 64'h3_0000_0000, 64'h1000_0000, 32'h0, 64'h0, 1'b1);
    set_dec(3, 64'h4_0000_0000, 64'h1000_0000, 32'h0, 64'h0, 1'b1);
    lookup(64'd5 * 1024 + 64'd77, 4, "R6", 1'b0);
    chk(port === 8'h15, "R7", "byte of high target word", 64'(port), 64'h15);
    lookup(64'd2 * 1024, 4, "R7", 1'b0);
    chk(port === 8'h12, "R7", "byte of low target word", 64'(port), 64'h12);

    // R2: low 28 bits of base and size words ignored
    set_dec(1, 64'h2_0FFF_FFFF, 64'h1FFF_FFFF, 32'h0, 64'hAA, 1'b1);
    lookup(64'h2_0000_0000, 4, "R2", 1'b0);
    chk(found === 1'b1 && port === 8'hAA, "R2", "aligned base hit", 64'(port), 64'hAA);
    lookup(64'h2_1000_0000, 4, "R2", 1'b0);

    // R3: end exclusive, base inclusive, no wrap
    set_dec(2, 64'h3_0000_0000, 64'h1000_0000, 32'h0, 64'h5B, 1'b1);
    lookup(64'h3_0FFF_FFFF, 4, "R3", 1'b0);
    lookup(64'h3_1000_0000, 4, "R3", 1'b0);
    lookup(64'h2_FFFF_FFFF, 4, "R3", 1'b0);
    set_dec(3, 64'hFFFF_FFFF_F000_0000, 64'h2000_0000, 32'h0, 64'h77, 1'b1);
    lookup(64'hFFFF_FFFF_FFFF_FFFF, 4, "R3", 1'b0);
    chk(found === 1'b1 && port === 8'h77, "R3", "top of space hit", 64'(port), 64'h77);
    lookup(64'h0000_0000_0800_0000, 4, "R3", 1'b0);
    chk(port === 8'h11 || port === 8'h10, "R3", "low address served by decoder 0 not wrap",
        64'(port), 64'h10);

    // R4 and R5: overlapping decoders 1 and 2
    set_dec(1, 64'h5_0000_0000, 64'h1000_0000, 32'h0, 64'h41, 1'b1);
    set_dec(2, 64'h5_0000_0000, 64'h1000_0000, 32'h0, 64'h42, 1'b1);
    lookup(64'h5_0000_0100, 4, "R4", 1'b0);
    chk(port === 8'h41, "R4", "lowest index wins", 64'(port), 64'h41);
    cm[1] = 1'b0;
    lookup(64'h5_0000_0100, 4, "R5", 1'b0);
    chk(found === 1'b0 && port === 8'h0, "R5", "uncommitted first hit aborts",
        {55'd0, found, port}, 64'd0);
    cm[1] = 1'b1;

    // R8 and R9: miss, count limits and clamping
    lookup(64'h9_0000_0000, 4, "R8", 1'b0);
    lookup(64'hFFFF_FFFF_F800_0000, 3, "R9", 1'b0);
    chk(found === 1'b0, "R9", "decoder above count skipped", 64'(found), 64'd0);
    lookup(64'hFFFF_FFFF_F800_0000, 7, "R9", 1'b0);
    chk(found === 1'b1, "R9", "count above bank clamped", 64'(found), 64'd1);
    lookup(64'h100, 0, "R9", 1'b0);

    // R11: start pulsed during a lookup
    lookup(64'hFFFF_FFFF_F000_0040, 4, "R11", 1'b1);

    // Random lookups against the model
    for (int k = 0; k < 300; k++) begin
      logic [63:0] a;
      int pick;
      for (int i = 0; i < N; i++) begin
        bl[i] = $urandom();
        bh[i] = $urandom_range(0, 3);
        sl[i] = $urandom();
        sh[i] = ($urandom_range(0, 3) == 0) ? 32'd1 : 32'd0;
        ct[i] = $urandom();
        tl[i] = $urandom();
        th[i] = $urandom();
        cm[i] = ($urandom_range(0, 4) != 0);
      end
      pick = $urandom_range(0, N - 1);
      a = {bh[pick], bl[pick][31:28], 28'h0} + {32'd0, $urandom()} +
          (($urandom_range(0, 1) == 1) ? {sh[pick], sl[pick][31:28], 28'h0} : 64'd0);
      if ($urandom_range(0, 7) == 0) a = {$urandom(), $urandom()};
      model(a, N, ef, ep, el);
      lookup(a, $urandom_range(0, 7), ef ? "R6" : "R8", 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule